// File: doc/BRIEF.md
# Execution Mode and Privilege Controller

This block keeps track of whether a small processor core is running ordinary thread code or an exception handler, and of whether the running code is privileged. The pipeline feeds it three kinds of event: a one-cycle pulse when an exception is taken, a one-cycle pulse when a handler returns, and writes to a control register. Bit 0 of that register asks for unprivileged thread execution. The block answers with the current mode, a privilege flag, and a one-cycle fault pulse for each refused write. The privilege flag is the grant that the core's special registers, the interrupt controller and the system timer consult before they accept an access.

Unprivileged thread code has no way to raise its own privilege. Its writes to the control register are dropped. The only path back to privileged thread execution is for an exception handler, which always runs privileged, to clear the control bit before it returns. A saturating depth counter tracks nested exceptions, and thread execution resumes only when the outermost handler returns.

Top module: `exec_priv_ctrl`

## Requirements
- R1: After reset the block reports thread mode (mode_o = 0), privileged (priv_o = 1), control bit 0, nesting depth 0 and no fault.
- R2: A control write accepted while privileged stores ctrl_wdata_i[0] as the control bit, which is visible on ctrl_rdata_o[0] after the next clock edge. While the block is in thread mode with the bit at 1, priv_o is 0. All upper bits of ctrl_rdata_o always read 0.
- R3: A control write made while unprivileged leaves the control bit unchanged. Unprivileged thread code stays unprivileged until an exception is taken.
- R4: An exception entry puts the block in handler mode (mode_o = 1) with priv_o = 1 after the next edge, whatever the value of the control bit.
- R5: A return that brings the depth to zero puts the block back in thread mode. priv_o is then the inverse of the control bit at that time, so a handler that changed the bit resumes thread code at the changed privilege level.
- R6: Each entry raises depth_o by one and each return lowers it by one. mode_o stays 1 while depth_o is non-zero.
- R7: A refused control write raises wr_fault_o for exactly the one cycle after the write edge. An accepted write raises no fault.
- R8: An entry at the largest depth leaves the depth at its maximum. A return at depth zero is ignored.
- R9: When an entry and a return arrive in the same cycle, the entry is taken first and the handler then returns at once, so the depth and the mode are unchanged.
- R10: A control write is judged against the privilege held before the clock edge, so a handler write made in the same cycle as its final return is accepted and sets the privilege of the resumed thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_enter_i | input | 1 | One-cycle pulse: exception taken |
| exc_return_i | input | 1 | One-cycle pulse: handler return |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | CTRL_W | Control register write data; bit 0 requests unprivileged thread execution |
| ctrl_rdata_o | output | CTRL_W | Control register contents (bit 0 only, upper bits zero) |
| mode_o | output | 1 | 0 = thread, 1 = handler |
| priv_o | output | 1 | 1 = privileged; grant for privileged-only resources |
| depth_o | output | DEPTH_W | Current exception nesting depth |
| wr_fault_o | output | 1 | One-cycle pulse after a refused control write |

## Verification
A wrong nesting depth appears on depth_o one edge after the event that caused it. It reaches mode_o at the latest when the faulty counter returns early to thread mode or keeps the block in handler mode after the outermost return. A lost or spurious control bit shows on ctrl_rdata_o right away, and on priv_o as soon as the block is in thread mode. A misjudged write shows within one cycle as a missing or extra fault pulse. Because every output comes straight from registered state, the bench compares all outputs against an arithmetic model after every edge, so any divergence is reported in the cycle where it first appears.

// File: rtl/exec_priv_pkg.sv
package exec_priv_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } exec_mode_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'b00,
        EV_LEAVE = 2'b01,
        EV_ENTER = 2'b10,
        EV_BOTH  = 2'b11
    } exc_event_e;

endpackage

// File: rtl/nest_depth_counter.sv
module nest_depth_counter #(
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter_i,
    input  logic               leave_i,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               active_o
);
    import exec_priv_pkg::*;

    localparam logic [DEPTH_W-1:0] DEPTH_MAX  = {DEPTH_W{1'b1}};
    localparam logic [DEPTH_W-1:0] DEPTH_ZERO = '0;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE  = DEPTH_W'(1);

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    exc_event_e ev;

    always_comb begin
        ev    = exc_event_e'({enter_i, leave_i});
        cnt_d = cnt_q;
        case (ev)
            EV_ENTER: if (cnt_q.depth != DEPTH_MAX)  cnt_d.depth = cnt_q.depth + DEPTH_ONE;
            EV_LEAVE: if (cnt_q.depth != DEPTH_ZERO) cnt_d.depth = cnt_q.depth - DEPTH_ONE;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign depth_o  = cnt_q.depth;
    assign active_o = (cnt_q.depth != DEPTH_ZERO);

    // R6
    depth_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !leave_i && depth_o != DEPTH_MAX) |=> depth_o == $past(depth_o) + DEPTH_ONE);
    // R6
    depth_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_i && !enter_i && depth_o != DEPTH_ZERO) |=> depth_o == $past(depth_o) - DEPTH_ONE);
    // R8
    depth_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !leave_i && depth_o == DEPTH_MAX) |=> depth_o == DEPTH_MAX);
    // R8
    depth_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_i && !enter_i && depth_o == DEPTH_ZERO) |=> depth_o == DEPTH_ZERO);
    // R9
    depth_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && leave_i) |=> $stable(depth_o));

endmodule

// File: rtl/ctrl_bit_gate.sv
module ctrl_bit_gate #(
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              priv_now_i,
    output logic              ctrl_bit_o,
    output logic              fault_o
);
    typedef struct packed {
        logic ctrl_bit;
        logic fault;
    } gate_state_t;

    gate_state_t gate_d, gate_q;

    always_comb begin
        gate_d       = gate_q;
        gate_d.fault = 1'b0;
        if (we_i) begin
            if (priv_now_i) gate_d.ctrl_bit = wdata_i[0];
            else            gate_d.fault    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign ctrl_bit_o = gate_q.ctrl_bit;
    assign fault_o    = gate_q.fault;

    generate
        if (CTRL_W > 1) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^wdata_i[CTRL_W-1:1];
        end
    endgenerate

    // R2
    ctrl_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && priv_now_i) |=> (ctrl_bit_o == $past(wdata_i[0])) && !fault_o);
    // R3
    ctrl_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !priv_now_i) |=> $stable(ctrl_bit_o));
    // R7
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o || $past(we_i));

endmodule

// File: rtl/exec_priv_ctrl.sv
module exec_priv_ctrl #(
    parameter int DEPTH_W = 3,
    parameter int CTRL_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_enter_i,
    input  logic               exc_return_i,
    input  logic               ctrl_we_i,
    input  logic [CTRL_W-1:0]  ctrl_wdata_i,
    output logic [CTRL_W-1:0]  ctrl_rdata_o,
    output logic               mode_o,
    output logic               priv_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               wr_fault_o
);
    import exec_priv_pkg::*;

    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    logic       in_handler;
    logic       ctrl_bit;
    exec_mode_e mode_cur;
    logic       priv_cur;

    nest_depth_counter #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_i  (exc_enter_i),
        .leave_i  (exc_return_i),
        .depth_o  (depth_o),
        .active_o (in_handler)
    );

    ctrl_bit_gate #(.CTRL_W(CTRL_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (ctrl_we_i),
        .wdata_i    (ctrl_wdata_i),
        .priv_now_i (priv_cur),
        .ctrl_bit_o (ctrl_bit),
        .fault_o    (wr_fault_o)
    );

    always_comb begin
        mode_cur = in_handler ? MODE_HANDLER : MODE_THREAD;
        priv_cur = (mode_cur == MODE_HANDLER) || !ctrl_bit;
    end

    assign mode_o       = mode_cur;
    assign priv_o       = priv_cur;
    assign ctrl_rdata_o = {{(CTRL_W-1){1'b0}}, ctrl_bit};

    // R3
    no_self_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_o && !exc_enter_i) |=> !priv_o);
    // R4
    entry_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter_i && !exc_return_i) |=> (mode_o == MODE_HANDLER) && priv_o);
    // R5
    return_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return_i && !exc_enter_i && !ctrl_we_i && depth_o == DEPTH_ONE)
        |=> (mode_o == MODE_THREAD) && (priv_o == !$past(ctrl_rdata_o[0])));
    // R2
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o >> 1) == '0);

endmodule

// File: tb/exec_priv_ctrl_test.sv
`timescale 1ns/1ps
module exec_priv_ctrl_test;
    localparam int DW = 2;
    localparam int CW = 32;
    localparam int DMAX = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, lv = 1'b0, we = 1'b0;
    logic [CW-1:0] wd = '0;
    logic [CW-1:0] rd;
    logic mode, priv, fault;
    logic [DW-1:0] depth;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int m_depth = 0;
    int m_ctrl = 0;
    int m_fault = 0;

    always #2 clk = ~clk;

    exec_priv_ctrl #(.DEPTH_W(DW), .CTRL_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .exc_enter_i(en), .exc_return_i(lv),
        .ctrl_we_i(we), .ctrl_wdata_i(wd), .ctrl_rdata_o(rd),
        .mode_o(mode), .priv_o(priv), .depth_o(depth), .wr_fault_o(fault)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int m_priv();
        return (m_depth != 0 || m_ctrl == 0) ? 1 : 0;
    endfunction

    task automatic compare_all(input string req);
        check(req, "mode",  int'(mode),  (m_depth != 0) ? 1 : 0);
        check(req, "priv",  int'(priv),  m_priv());
        check(req, "ctrl",  int'(rd),    m_ctrl);
        check(req, "depth", int'(depth), m_depth);
        check(req, "fault", int'(fault), m_fault);
    endtask

    // one clock cycle with given inputs; model updated, outputs compared 1 ns after the edge
    task automatic cyc(input logic e, input logic l, input logic w, input int data, input string req);
        int nd;
        @(negedge clk);
        en = e; lv = l; we = w; wd = CW'(data);
        nd = m_depth;
        if (e && !l)      nd = (m_depth == DMAX) ? DMAX : m_depth + 1;
        else if (l && !e) nd = (m_depth == 0) ? 0 : m_depth - 1;
        m_fault = 0;
        if (w) begin
            if (m_priv() == 1) m_ctrl = data & 1;
            else               m_fault = 1;
        end
        m_depth = nd;
        @(posedge clk);
        #1;
        compare_all(req);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        compare_all("R1");

        cyc(0, 0, 1, 32'hFFFF_FFFF, "R2");   // privileged write sets bit, upper bits read zero
        check("R2", "priv low in unprivileged thread", int'(priv), 0);
        cyc(0, 0, 1, 0, "R3");               // refused
        check("R7", "fault after refused write", int'(fault), 1);
        cyc(0, 0, 0, 0, "R7");
        check("R7", "fault lasts one cycle", int'(fault), 0);
        cyc(0, 1, 0, 0, "R8");               // return at depth 0 ignored
        cyc(1, 0, 0, 0, "R4");               // entry while bit set
        check("R4", "handler privileged", int'(priv), 1);
        cyc(1, 0, 0, 0, "R6");
        cyc(0, 1, 0, 0, "R6");
        check("R6", "still handler at depth 1", int'(mode), 1);
        cyc(0, 1, 0, 0, "R5");               // back to unprivileged thread
        check("R5", "resume unprivileged", int'(priv), 0);
        cyc(1, 0, 0, 0, "R4");
        cyc(0, 0, 1, 0, "R5");               // handler clears bit
        cyc(0, 1, 0, 0, "R5");
        check("R5", "resume privileged", int'(priv), 1);
        cyc(1, 1, 0, 0, "R9");               // simultaneous at depth 0
        check("R9", "thread kept", int'(mode), 0);
        for (int i = 0; i < DMAX + 2; i++) cyc(1, 0, 0, 0, "R8");
        check("R8", "saturated depth", int'(depth), DMAX);
        cyc(1, 1, 0, 0, "R9");
        for (int i = 0; i < DMAX - 1; i++) cyc(0, 1, 0, 0, "R6");
        cyc(0, 1, 1, 1, "R10");              // write with final return
        check("R10", "resume unprivileged after same-cycle write", int'(priv), 0);
        cyc(0, 0, 1, 0, "R3");

        // near-exhaustive sweep over all input combinations from reached states
        for (int i = 0; i < 6000; i++) begin
            int pat;
            pat = (i < 64) ? (i % 16) : int'($urandom % 16);
            cyc(pat[0], pat[1], pat[2], pat[3], "R6");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule